// File: doc/BRIEF.md
# Two-Level Reservation Output Arbiter

This block decides which input of a five-port crossbar router may drive one output port. Each input can claim the output at two levels. A firm claim comes from an input whose packet has been routed and allocated in the normal way. A tentative claim comes from an idle input that has predicted this output for its next packet, so the crossbar path is set up before any flit arrives. A head flit that arrives on the predicted path then crosses without waiting for arbitration. One instance serves each output port.

Firm claims always outrank tentative ones. Within a level, a round-robin pointer of its own breaks ties. A tentative grant is cancelled when its owner raises a kill, which it does when routing shows the prediction was wrong. A firm claim can take the output from a tentative holder, but only before any flit has crossed under that tentative grant. A grant stays with its owner until the owner's tail flit has crossed. The output is then free, and arbitration resumes on the next cycle.

Top module: `resv_out_arbiter`

## Requirements
- R1: After reset, and whenever the output is free, `grant` is all zeros and `grant_tent` is 0. At all times `grant` has at most one bit set.
- R2: When the output is free and any `firm_req` bit is set, the next cycle grants a firm requester (`grant_tent` = 0), even if `tent_req` bits are also set.
- R3: When the output is free, no `firm_req` bit is set and some `tent_req` bit is set, the next cycle grants a tentative requester with `grant_tent` = 1.
- R4: A `kill` from the owner of a tentative grant frees the output on the next cycle, whether or not flits have crossed. This applies unless R6 pre-empts in that same cycle.
- R5: A held grant does not change while its requests drop or while non-tail flits cross.
- R6: While no flit has crossed under a tentative grant, any set `firm_req` bit moves the grant on the next cycle to the firm winner with `grant_tent` = 0. This pre-emption takes precedence over a kill in the same cycle.
- R7: A cycle with `xfer` and `tail` both set on the owner's bit frees the output on the next cycle.
- R8: Once the tentative owner has crossed one flit (`xfer` on its bit), a firm request no longer pre-empts that grant.
- R9: Each level keeps its own round-robin pointer. The pointer resets to input 0. The search starts at the pointer and goes upward, wrapping past input 4. After a grant at a level, that level's pointer moves to the input just after the winner.
- R10: A `kill` has no effect on a firm grant or on an input that does not hold the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| firm_req | input | 5 | Firm claim per input (bit i = input i) |
| tent_req | input | 5 | Tentative, prediction-based claim per input |
| kill | input | 5 | Cancel a tentative claim, per input |
| xfer | input | 5 | A flit from input i crosses to this output this cycle |
| tail | input | 5 | The crossing flit from input i is the packet's tail |
| grant | output | 5 | One-hot grant, registered |
| grant_tent | output | 1 | Held grant is tentative |

## Verification
The interaction that matters most is a kill from the tentative owner arriving in the same cycle as a firm request from another input. The bench provokes it on an unused tentative grant and expects the firm requester to win on the next cycle. It also raises a firm request on a tentative grant that has already passed a flit. In that case the grant must hold, and only a later kill may free it. Each case is judged by the one-hot grant and the level flag, sampled one cycle after the stimulus.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned PORTS = 5;
  typedef enum logic {LVL_FIRM = 1'b0, LVL_TENT = 1'b1} level_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          win_valid,
  output logic [IW-1:0] win_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q, ptr_d;

  // search from ptr upward; iterate downward so the closest hit is kept last
  always_comb begin
    int j;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = int'(ptr_q) + k;
      if (j >= int'(N)) j = j - int'(N);
      if (req[j]) begin
        win_valid = 1'b1;
        win_idx   = IW'(j);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (win_idx == LAST) ? '0 : win_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl
  import arb_pkg::*;
#(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          firm_any,
  input  logic [IW-1:0] firm_idx,
  input  logic          tent_any,
  input  logic [IW-1:0] tent_idx,
  input  logic          own_kill,
  input  logic          own_xfer,
  input  logic          own_tail,
  output logic          busy,
  output level_e        level,
  output logic [IW-1:0] owner,
  output logic          take_firm,
  output logic          take_tent
);
  logic          busy_d, sent_q, sent_d;
  level_e        level_d;
  logic [IW-1:0] owner_d;

  always_comb begin
    busy_d    = busy;
    level_d   = level;
    owner_d   = owner;
    sent_d    = sent_q;
    take_firm = 1'b0;
    take_tent = 1'b0;
    if (!busy) begin
      if (firm_any) begin
        take_firm = 1'b1;
        busy_d = 1'b1; level_d = LVL_FIRM; owner_d = firm_idx; sent_d = 1'b0;
      end else if (tent_any) begin
        take_tent = 1'b1;
        busy_d = 1'b1; level_d = LVL_TENT; owner_d = tent_idx; sent_d = 1'b0;
      end
    end else if (level == LVL_TENT) begin
      if (!sent_q && firm_any) begin
        take_firm = 1'b1;
        level_d = LVL_FIRM; owner_d = firm_idx; sent_d = 1'b0;
      end else if (own_kill) begin
        busy_d = 1'b0; level_d = LVL_FIRM; sent_d = 1'b0;
      end else if (own_xfer && own_tail) begin
        busy_d = 1'b0; level_d = LVL_FIRM; sent_d = 1'b0;
      end else if (own_xfer) begin
        sent_d = 1'b1;
      end
    end else begin
      if (own_xfer && own_tail) begin
        busy_d = 1'b0; sent_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      level  <= LVL_FIRM;
      owner  <= '0;
      sent_q <= 1'b0;
    end else begin
      busy   <= busy_d;
      level  <= level_d;
      owner  <= owner_d;
      sent_q <= sent_d;
    end
  end
endmodule

// File: rtl/resv_out_arbiter.sv
module resv_out_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N  = PORTS,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] firm_req,
  input  logic [N-1:0] tent_req,
  input  logic [N-1:0] kill,
  input  logic [N-1:0] xfer,
  input  logic [N-1:0] tail,
  output logic [N-1:0] grant,
  output logic         grant_tent
);
  logic [1:0]    lvl_valid, lvl_adv;
  logic [IW-1:0] lvl_idx [2];
  logic [N-1:0]  lvl_req [2];
  logic          busy, take_firm, take_tent;
  level_e        level;
  logic [IW-1:0] owner;

  assign lvl_req[0] = firm_req;
  assign lvl_req[1] = tent_req;
  assign lvl_adv    = {take_tent, take_firm};

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    rr_pick #(.N(N)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (lvl_req[g]),
      .adv       (lvl_adv[g]),
      .win_valid (lvl_valid[g]),
      .win_idx   (lvl_idx[g])
    );
  end

  hold_ctrl #(.N(N)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .firm_any  (lvl_valid[0]),
    .firm_idx  (lvl_idx[0]),
    .tent_any  (lvl_valid[1]),
    .tent_idx  (lvl_idx[1]),
    .own_kill  (kill[owner]),
    .own_xfer  (xfer[owner]),
    .own_tail  (tail[owner]),
    .busy      (busy),
    .level     (level),
    .owner     (owner),
    .take_firm (take_firm),
    .take_tent (take_tent)
  );

  always_comb begin
    grant = '0;
    if (busy) grant[owner] = 1'b1;
  end
  assign grant_tent = busy && (level == LVL_TENT);
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] firm_req,
  input logic [N-1:0] tent_req,
  input logic [N-1:0] kill,
  input logic [N-1:0] xfer,
  input logic [N-1:0] tail,
  input logic [N-1:0] grant,
  input logic         grant_tent
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_tent -> |grant));

  a_r2_firm_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && |firm_req) |=> (|grant && !grant_tent));

  a_r3_tent_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && firm_req == '0 && |tent_req) |=> (|grant && grant_tent));

  a_r4_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_tent && |(grant & kill) && firm_req == '0) |=> (grant == '0));

  a_r5_firm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !grant_tent && !(|(grant & xfer & tail))) |=> $stable(grant));

  a_r7_tail_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !grant_tent && |(grant & xfer & tail)) |=> (grant == '0));
endmodule

bind resv_out_arbiter arb_checker #(.N(N)) u_arb_checker (
  .clk(clk), .rst_n(rst_n), .firm_req(firm_req), .tent_req(tent_req),
  .kill(kill), .xfer(xfer), .tail(tail), .grant(grant), .grant_tent(grant_tent)
);

// File: tb/test_resv_out_arbiter.sv
module test_resv_out_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] firm_req, tent_req, kill, xfer, tail;
  logic [4:0] grant;
  logic       grant_tent;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  resv_out_arbiter i_resv_out_arbiter (
    .clk(clk), .rst_n(rst_n), .firm_req(firm_req), .tent_req(tent_req),
    .kill(kill), .xfer(xfer), .tail(tail), .grant(grant), .grant_tent(grant_tent)
  );

  task automatic expect_g(input string req, input logic [4:0] g, input logic t);
    checks++;
    if (grant !== g || grant_tent !== t) begin
      errors++;
      $display("FAIL %s grant=%b tent=%b expected grant=%b tent=%b", req, grant, grant_tent, g, t);
    end
  endtask

  // drive at negedge, one posedge passes, sample at the next negedge
  task automatic cyc(input logic [4:0] f, input logic [4:0] tq, input logic [4:0] k,
                     input logic [4:0] x, input logic [4:0] tl);
    firm_req = f; tent_req = tq; kill = k; xfer = x; tail = tl;
    @(negedge clk);
  endtask

  task automatic quiet();
    cyc('0, '0, '0, '0, '0);
  endtask

  task automatic t_reset();
    expect_g("R1 reset", 5'b0, 1'b0);
  endtask

  task automatic t_tent_kill();
    cyc('0, 5'b00010, '0, '0, '0);
    expect_g("R3 tentative from idle", 5'b00010, 1'b1);
    quiet();
    expect_g("R5 tentative held after request drops", 5'b00010, 1'b1);
    cyc('0, '0, 5'b00100, '0, '0);
    expect_g("R10 kill from non-owner ignored", 5'b00010, 1'b1);
    cyc('0, '0, 5'b00010, '0, '0);
    expect_g("R4 kill frees", 5'b0, 1'b0);
    quiet();
    expect_g("R1 stays free", 5'b0, 1'b0);
  endtask

  task automatic t_preempt_release();
    cyc('0, 5'b00010, '0, '0, '0);
    expect_g("R3 tentative again", 5'b00010, 1'b1);
    cyc(5'b01000, '0, '0, '0, '0);
    expect_g("R6 firm pre-empts unused tentative", 5'b01000, 1'b0);
    cyc('0, '0, '0, 5'b01000, '0);
    expect_g("R5 firm held over body flit", 5'b01000, 1'b0);
    cyc('0, '0, '0, 5'b01000, 5'b01000);
    expect_g("R7 tail frees", 5'b0, 1'b0);
  endtask

  task automatic t_no_preempt_after_send();
    cyc('0, 5'b00001, '0, '0, '0);
    expect_g("R9 tentative pointer at 2 wraps to 0", 5'b00001, 1'b1);
    cyc('0, '0, '0, 5'b00001, '0);
    expect_g("R5 tentative held over head", 5'b00001, 1'b1);
    cyc(5'b00100, '0, '0, '0, '0);
    expect_g("R8 firm does not pre-empt used tentative", 5'b00001, 1'b1);
    cyc(5'b00100, '0, 5'b00001, '0, '0);
    expect_g("R4 kill frees after flits crossed", 5'b0, 1'b0);
    cyc(5'b00100, '0, '0, '0, '0);
    expect_g("R2 firm granted after kill", 5'b00100, 1'b0);
    cyc('0, '0, '0, 5'b00100, 5'b00100);
    expect_g("R7 tail frees", 5'b0, 1'b0);
  endtask

  task automatic t_firm_over_tent_and_rr();
    cyc(5'b00010, 5'b01000, '0, '0, '0);
    expect_g("R2 firm beats tentative at idle", 5'b00010, 1'b0);
    cyc('0, '0, 5'b00010, '0, '0);
    expect_g("R10 kill ignored on firm grant", 5'b00010, 1'b0);
    cyc('0, '0, '0, 5'b00010, 5'b00010);
    cyc(5'b10101, '0, '0, '0, '0);
    expect_g("R9 firm rr picks 2", 5'b00100, 1'b0);
    cyc('0, '0, '0, 5'b00100, 5'b00100);
    cyc(5'b10101, '0, '0, '0, '0);
    expect_g("R9 firm rr picks 4", 5'b10000, 1'b0);
    cyc('0, '0, '0, 5'b10000, 5'b10000);
    cyc(5'b10101, '0, '0, '0, '0);
    expect_g("R9 firm rr wraps to 0", 5'b00001, 1'b0);
    cyc('0, '0, '0, 5'b00001, 5'b00001);
    expect_g("R7 tail frees", 5'b0, 1'b0);
  endtask

  task automatic t_kill_and_firm_same_cycle();
    cyc('0, 5'b00100, '0, '0, '0);
    expect_g("R3 tentative to 2", 5'b00100, 1'b1);
    cyc(5'b10000, '0, 5'b00100, '0, '0);
    expect_g("R6 pre-empt wins over same-cycle kill", 5'b10000, 1'b0);
    cyc('0, '0, '0, 5'b10000, 5'b10000);
    cyc('0, 5'b00011, '0, '0, '0);
    expect_g("R9 tentative rr from 3 wraps to 0", 5'b00001, 1'b1);
    cyc('0, '0, '0, 5'b00001, 5'b00001);
    expect_g("R7 tail frees tentative", 5'b0, 1'b0);
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    firm_req = '0; tent_req = '0; kill = '0; xfer = '0; tail = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tent_kill();
    t_preempt_release();
    t_no_preempt_after_send();
    t_firm_over_tent_and_rr();
    t_kill_and_firm_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule